// File: doc/BRIEF.md
# Cartridge Read Start Delay Timer

This block decides when a cartridge bus read becomes ready. Software writes a 32-bit control word together with a block size. Nothing becomes ready at the moment of the write. The write only arms a one-shot countdown. The countdown length is built from three parts: an 8-byte command phase, a programmable gap, and a short allowance when a data phase follows. Each byte costs a number of bus clocks, and a rate-select bit in the control word picks that cost. The countdown runs on a base clock that is twice the bus rate, so the bus-clock delay is doubled.

When the countdown expires, the block sets a data-ready flag in the readable control word and raises a one-cycle DMA request for cartridge transfers. If software writes a new control word while a countdown is still running, the running countdown is dropped and a new deadline is computed from the new word. The ready flag stays set until the next control write or a reset clears it.

Top module: `cart_xfer_timer`

## Requirements
- R1: A control write never sets the ready flag. In the cycle after the write edge, `xfer_ready` is 0, `rdata` bit 23 is 0 and `busy` is 1.
- R2: Control bit 27 selects the cost of one byte: 8 bus clocks when it is 1, 5 bus clocks when it is 0.
- R3: The gap length in bytes is control bits 12:0. Bits 13 to 22 and bits 24 to 26 and 28 to 31 have no effect on timing.
- R4: The bus-clock delay is (8 + gap) multiplied by the per-byte cost.
- R5: When `blk_size` is nonzero at the write, 4 bus clocks are added to the delay. When `blk_size` is zero, nothing is added.
- R6: The countdown lasts twice the bus-clock delay, counted in `clk` cycles. `dma_req` and `xfer_ready` are first seen high exactly that many cycles after the write edge.
- R7: On expiry, `xfer_ready` and `rdata` bit 23 go to 1 and stay at 1 until the next write. `dma_req` is high for exactly one cycle.
- R8: The countdown fires only once per write. After it fires, `busy` is 0 and no further `dma_req` appears.
- R9: A write during a running countdown replaces the deadline. Only the new deadline produces a `dma_req`.
- R10: `rdata` returns the last written word with bit 23 replaced by the ready flag.
- R11: While `rst_n` is low at a clock edge, the stored word, the ready flag, the countdown and `dma_req` are all cleared. Any pending event is cancelled.
- R12: A write that lands on the same edge on which the old countdown would have fired wins. The old event does not fire, and the new deadline applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, twice the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word to write |
| blk_size | input | 3 | Block size sampled with the write; 0 means no data phase |
| rdata | output | 32 | Control word readback with ready flag at bit 23 |
| xfer_ready | output | 1 | Data-ready flag |
| dma_req | output | 1 | One-cycle cartridge DMA request |
| busy | output | 1 | A countdown is pending |

## Verification
The assertions take two things for granted about the inputs. First, `ctrl_wr`, `ctrl_wdata` and `blk_size` are settled, known values at every rising edge after reset. Second, `blk_size` matters only on the write edge. The shortest possible countdown is 80 cycles, and the single-pulse check on `dma_req` relies on that. The bench changes every input only at falling edges. It holds `rst_n` low from time zero, and it lets at least one full countdown pass, or deliberately replaces it, before each new request. The only exceptions are the cases that test replacement, collision with a firing edge, and reset on purpose.

// File: rtl/cxt_pkg.sv
// Package: shared types for the cartridge read start delay timer.
// Assumes: nothing beyond being compiled ahead of the modules that use it.
package cxt_pkg;

    // State of the one-shot countdown.
    typedef enum logic {
        CXT_IDLE = 1'b0,
        CXT_WAIT = 1'b1
    } cxt_state_e;

endpackage

// File: rtl/cxt_delay_calc.sv
// Module: cxt_delay_calc
// What it does: turns the rate select, the gap field and the block size into a
// countdown length in base-clock ticks.
// Assumes: CNT_W is wide enough for the largest gap at the slow-per-byte maximum.
module cxt_delay_calc #(
    parameter int GAP_W      = 13,
    parameter int SIZE_W     = 3,
    parameter int CNT_W      = 18,
    parameter int CMD_BYTES  = 8,
    parameter int SLOW_COST  = 5,
    parameter int FAST_COST  = 8,
    parameter int DATA_EXTRA = 4,
    parameter int TICK_MULT  = 2
) (
    input  logic              fast_sel,
    input  logic [GAP_W-1:0]  gap,
    input  logic [SIZE_W-1:0] blk_size,
    output logic [CNT_W-1:0]  ticks
);

    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] per_byte;
    logic [CNT_W-1:0] extra;
    logic [CNT_W-1:0] bus_clks;

    // Purpose: combine command length, gap, per-byte cost and data allowance.
    always_comb begin
        byte_cnt = CNT_W'(CMD_BYTES) + CNT_W'(gap);
        per_byte = fast_sel ? CNT_W'(FAST_COST) : CNT_W'(SLOW_COST);
        extra    = (|blk_size) ? CNT_W'(DATA_EXTRA) : '0;
        bus_clks = byte_cnt * per_byte + extra;
        ticks    = bus_clks * CNT_W'(TICK_MULT);
    end

endmodule

// File: rtl/cxt_countdown.sv
// Module: cxt_countdown
// What it does: a one-shot countdown that is armed by load and fires once when
// it reaches its end. A new load restarts it, and a load on the firing edge wins.
// Assumes: load_ticks is at least 2, so a loaded count never underflows.
module cxt_countdown
    import cxt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_ticks,
    output logic             pending,
    output logic             fire
);

    cxt_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Purpose: arm, count down and disarm the pending event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CXT_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= CXT_WAIT;
            cnt   <= load_ticks - CNT_W'(1);
        end else if (state == CXT_WAIT) begin
            if (cnt == '0) begin
                state <= CXT_IDLE;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // Purpose: flag the last counted cycle; a simultaneous load suppresses it.
    always_comb begin
        pending = (state == CXT_WAIT);
        fire    = pending && (cnt == '0) && !load;
    end

    // R6: the count steps down by one each cycle while waiting.
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !load && cnt != '0) |=> (pending && cnt == $past(cnt) - CNT_W'(1)));

    // R8: after firing, the event is gone unless re-armed.
    p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !pending);

    // R9: a load re-arms the deadline from the newly computed length.
    p_load_rearms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pending && cnt == $past(load_ticks) - CNT_W'(1)));

endmodule

// File: rtl/cxt_ctrl_reg.sv
// Module: cxt_ctrl_reg
// What it does: holds the written control word, the sticky ready flag and the
// registered one-cycle DMA request. It also forms the readback word.
// Assumes: fire is never high on a cycle where wr is high.
module cxt_ctrl_reg #(
    parameter int DATA_W  = 32,
    parameter int RDY_BIT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              dma_req
);

    localparam logic [DATA_W-1:0] RDY_MASK = DATA_W'(1) << RDY_BIT;

    logic [DATA_W-1:0] word_q;

    // Purpose: store the word, clear ready on a write, set it and pulse DMA on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            ready   <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            dma_req <= fire;
            if (wr) begin
                word_q <= wdata & ~RDY_MASK;
                ready  <= 1'b0;
            end else if (fire) begin
                ready  <= 1'b1;
            end
        end
    end

    // Purpose: merge the live ready flag into the readback word.
    always_comb begin
        rdata = word_q | (ready ? RDY_MASK : '0);
    end

    // R7: the DMA request never lasts more than one cycle.
    p_dma_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    // R7: a DMA request is always seen together with the ready flag.
    p_dma_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> ready);

    // R7: ready holds until a write clears it.
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr) |=> ready);

    // R1: a write leaves ready cleared on the next cycle.
    p_write_clears_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!ready && !rdata[RDY_BIT]));

endmodule

// File: rtl/cart_xfer_timer.sv
// Module: cart_xfer_timer
// What it does: top level of the cartridge read start delay timer. It decodes the
// control word fields, computes the delay, and runs the countdown that sets ready
// and requests DMA.
// Assumes: inputs are synchronous to clk; blk_size is meaningful only with ctrl_wr.
module cart_xfer_timer #(
    parameter int DATA_W     = 32,
    parameter int SIZE_W     = 3,
    parameter int GAP_W      = 13,
    parameter int RDY_BIT    = 23,
    parameter int RATE_BIT   = 27,
    parameter int CMD_BYTES  = 8,
    parameter int SLOW_COST  = 5,
    parameter int FAST_COST  = 8,
    parameter int DATA_EXTRA = 4,
    parameter int TICK_MULT  = 2,
    parameter int CNT_W      = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic [SIZE_W-1:0] blk_size,
    output logic [DATA_W-1:0] rdata,
    output logic              xfer_ready,
    output logic              dma_req,
    output logic              busy
);

    logic             fast_sel;
    logic [GAP_W-1:0] gap;
    logic [CNT_W-1:0] ticks;
    logic             fire;

    // Purpose: pick the rate select and gap fields out of the written word.
    always_comb begin
        fast_sel = ctrl_wdata[RATE_BIT];
        gap      = ctrl_wdata[GAP_W-1:0];
    end

    cxt_delay_calc #(
        .GAP_W      (GAP_W),
        .SIZE_W     (SIZE_W),
        .CNT_W      (CNT_W),
        .CMD_BYTES  (CMD_BYTES),
        .SLOW_COST  (SLOW_COST),
        .FAST_COST  (FAST_COST),
        .DATA_EXTRA (DATA_EXTRA),
        .TICK_MULT  (TICK_MULT)
    ) u_calc (
        .fast_sel (fast_sel),
        .gap      (gap),
        .blk_size (blk_size),
        .ticks    (ticks)
    );

    cxt_countdown #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctrl_wr),
        .load_ticks (ticks),
        .pending    (busy),
        .fire       (fire)
    );

    cxt_ctrl_reg #(
        .DATA_W  (DATA_W),
        .RDY_BIT (RDY_BIT)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .wdata   (ctrl_wdata),
        .fire    (fire),
        .rdata   (rdata),
        .ready   (xfer_ready),
        .dma_req (dma_req)
    );

    // R1: a write always leaves a pending event behind it.
    p_write_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> busy);

    // R8: a DMA request only follows an event that has just ended.
    p_dma_after_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(busy));

endmodule

// File: tb/tb_cart_xfer_timer.sv
// Bench: scoreboard for cart_xfer_timer. The driver queues expected firing
// cycles, and a monitor pops and compares them whenever dma_req appears.
module tb_cart_xfer_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [2:0]  blk_size = '0;
    logic [31:0] rdata;
    logic        xfer_ready;
    logic        dma_req;
    logic        busy;

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    int exp_q[$];
    bit prev_dma = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    cart_xfer_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .blk_size   (blk_size),
        .rdata      (rdata),
        .xfer_ready (xfer_ready),
        .dma_req    (dma_req),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference delay from the requirements (R2..R6).
    function automatic int ref_ticks(input logic [31:0] w, input int sz);
        int cost;
        int d;
        cost = w[27] ? 8 : 5;
        d = (8 + int'(w[12:0])) * cost + ((sz != 0) ? 4 : 0);
        return 2 * d;
    endfunction

    // Driver: called at a falling edge; pushes the expected firing cycle.
    task automatic do_write(input logic [31:0] w, input int sz);
        exp_q.delete();                         // R9/R12: replacement drops old deadline
        exp_q.push_back(cyc + 1 + ref_ticks(w, sz));
        ctrl_wr    = 1'b1;
        ctrl_wdata = w;
        blk_size   = 3'(sz);
        @(negedge clk);
        ctrl_wr    = 1'b0;
        blk_size   = '0;
        chk(xfer_ready == 1'b0 && busy == 1'b1, "R1", "no ready right after write",
            {xfer_ready, busy}, 2'b01);
        chk(rdata == (w & ~32'h0080_0000), "R10", "readback after write",
            rdata, w & ~32'h0080_0000);
    endtask

    task automatic wait_done();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each DMA pulse against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected dma_req", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, "R6", "dma_req cycle", cyc, e);
                    chk(xfer_ready && rdata[23], "R7", "ready with dma",
                        {xfer_ready, rdata[23]}, 2'b11);
                end
                if (prev_dma) chk(1'b0, "R7", "dma_req longer than one cycle", 2, 1);
            end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
                chk(1'b0, "R6", "dma_req missed", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            prev_dma <= dma_req;
        end else begin
            prev_dma <= 1'b0;
        end
    end

    initial begin
        #(8 * 190000);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_ready == 0 && dma_req == 0 && busy == 0 && rdata == 0, "R11",
            "reset state", rdata, 0);

        // R2/R4: slow cost, no gap, no data -> 80
        w = 32'h0000_0000;
        do_write(w, 0);
        wait_done();
        chk(rdata == (w | 32'h0080_0000), "R10", "readback with ready", rdata, w | 32'h0080_0000);
        chk(dma_req == 0 && xfer_ready == 1, "R7", "pulse ended, ready held",
            {dma_req, xfer_ready}, 2'b01);

        // R2: fast cost -> 128
        do_write(32'h0800_0000, 0);
        wait_done();

        // R4/R5: fast, gap 10, data -> 296
        do_write(32'h0800_000A, 3);
        wait_done();

        // R5: slow, gap 5, data -> 138
        do_write(32'h0000_0005, 1);
        wait_done();

        // R3: junk above the gap field and bit 23 in write data -> 110
        w = 32'hF4FF_E003;
        do_write(w, 0);
        wait_done();
        chk(rdata == (w | 32'h0080_0000), "R3", "junk bits kept, timing unaffected",
            rdata, w | 32'h0080_0000);

        // R8: one-shot, nothing more fires
        repeat (400) @(negedge clk);
        chk(busy == 0 && xfer_ready == 1, "R8", "idle and ready after fire",
            {busy, xfer_ready}, 2'b01);

        // R11: reset cancels a pending event
        do_write(32'h0000_0002, 0);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && xfer_ready == 0 && rdata == 0, "R11", "reset mid countdown",
            rdata, 0);
        repeat (200) @(negedge clk);
        chk(busy == 0, "R11", "no event after reset", busy, 0);

        // R9: replacement with a shorter deadline
        do_write(32'h0000_0064, 0);
        repeat (30) @(negedge clk);
        do_write(32'h0800_0000, 0);
        wait_done();
        repeat (1200) @(negedge clk);
        chk(busy == 0, "R9", "only one event after replacement", busy, 0);

        // R12: write on the firing edge wins
        c0 = cyc;
        do_write(32'h0000_0000, 0);
        while (cyc < c0 + 80) @(negedge clk);
        do_write(32'h0800_0002, 0);
        wait_done();

        // R3: largest gap, slow -> 81990
        do_write(32'h0000_1FFF, 0);
        wait_done();

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule